// File: doc/BRIEF.md
# Edge-Select Interrupt Status Unit

This unit gathers sixteen internal event lines of a small mixed-signal peripheral into one interrupt request. Each line has its own rising-edge enable bit and falling-edge enable bit. A transition that matches an enabled edge latches the line's bit in a sticky status register. The interrupt output is high while any status bit is set. Bit 11 is the conversion-done event and bit 12 is the panel-contact event. The other lines are generic.

Software reaches the unit through a synchronous register port with a 7-bit address and 16-bit data. One address serves both as the status register on read and as the clear register on write. A clear is done in two steps: write a mask of ones, then write zero. While a bit of the clear register holds a one, the matching status bit is forced to zero and cannot be set. Writing all ones and then zero clears every pending source in one go.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset, the rising-enable register, the falling-enable register, the clear register, the status register, `irq_o` and `bus_rdata_o` are all zero.
- R2: The rising-enable register sits at address 0x5E and the falling-enable register at 0x60. Reading either returns the last value written to it.
- R3: Line i is compared with its value one clock earlier. If it goes from 0 to 1 while rising-enable bit i is 1, status bit i sets on that clock. Reading address 0x62 returns the status word, with bit 11 for conversion-done and bit 12 for panel contact.
- R4: If line i goes from 1 to 0 while falling-enable bit i is 1, status bit i sets.
- R5: An edge whose enable bit is 0 leaves status unchanged. Writing 0 to address 0x60 stops falling-edge capture on every line.
- R6: Status bits are sticky. A set bit stays set after its line returns to the old level, and later edges on other lines do not disturb it.
- R7: Writing a mask to 0x62 clears the status bits where the mask is 1, on the clock of the write. Bits where the mask is 0 are untouched.
- R8: While a clear-register bit holds 1, the matching status bit stays 0 and enabled edges on that line are dropped. Once 0 is written to 0x62, capture on that line resumes.
- R9: Writing 0xFFFF and then 0 to 0x62 clears all pending status bits.
- R10: `irq_o` is the OR of the status bits, registered. It rises or falls one clock after the status change.
- R11: Read data is registered. `bus_rdata_o` takes the addressed value on the clock where `bus_rd_i` is high and holds it otherwise. An unmapped address reads 0, and a write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 16 | Event lines, already synchronous to clk |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 7 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request, OR of the status bits |

## Verification
The bench holds a clear bit at one, raises an enabled edge on that line, and expects the status to stay zero. A design that cleared only on the write pulse would let that edge latch. It then mixes rising and falling enables on the same lines and turns off the falling enables with a single zero write, so a design that swaps the two registers or ignores a zero write reports spurious status bits. The bench times `irq_o` against the status change. A combinational output shows up a cycle early, and a design that does not drop the interrupt after a full clear stays high. Partial clears must leave the other pending bits untouched.

// File: rtl/eisu_pkg.sv
package eisu_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_RISE_EN = 7'h5E;
  localparam logic [ADDR_W-1:0] ADDR_FALL_EN = 7'h60;
  localparam logic [ADDR_W-1:0] ADDR_STS_CLR = 7'h62;

  localparam int SRC_CONV_DONE = 11;
  localparam int SRC_PANEL_TOUCH = 12;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RISE = 2'd1,
    SEL_FALL = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e addr_decode(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_RISE_EN: return SEL_RISE;
      ADDR_FALL_EN: return SEL_FALL;
      ADDR_STS_CLR: return SEL_STAT;
      default:      return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/eisu_edge_det.sv
module eisu_edge_det #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] rise_en_i,
  input  logic [NSRC-1:0] fall_en_i,
  output logic [NSRC-1:0] set_o
);
  logic [NSRC-1:0] evt_q;
  logic [NSRC-1:0] rise_w;
  logic [NSRC-1:0] fall_w;

  function automatic logic [NSRC-1:0] edge_hits(input logic [NSRC-1:0] r,
                                                input logic [NSRC-1:0] f,
                                                input logic [NSRC-1:0] ren,
                                                input logic [NSRC-1:0] fen);
    return (r & ren) | (f & fen);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_i;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_lane
    assign rise_w[i] = evt_i[i] & ~evt_q[i];
    assign fall_w[i] = ~evt_i[i] & evt_q[i];
  end

  assign set_o = edge_hits(rise_w, fall_w, rise_en_i, fall_en_i);

  // R5
  no_set_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == evt_q) |-> (set_o == '0));
endmodule

// File: rtl/eisu_regs.sv
module eisu_regs
  import eisu_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   status_i,
  output logic [NSRC-1:0]   rise_en_o,
  output logic [NSRC-1:0]   fall_en_o,
  output logic [NSRC-1:0]   clr_mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e          sel;
  logic [NSRC-1:0]   rise_q, fall_q, clr_q;
  logic [DATA_W-1:0] rd_mux;
  logic              clr_wr;

  assign sel    = addr_decode(addr);
  assign clr_wr = wr_en && (sel == SEL_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      clr_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_RISE: rise_q <= wdata[NSRC-1:0];
        SEL_FALL: fall_q <= wdata[NSRC-1:0];
        SEL_STAT: clr_q  <= wdata[NSRC-1:0];
        default: ;
      endcase
    end
  end

  // a clear write acts on the clock it is written
  assign clr_mask_o = clr_wr ? wdata[NSRC-1:0] : clr_q;
  assign rise_en_o  = rise_q;
  assign fall_en_o  = fall_q;

  always_comb begin
    case (sel)
      SEL_RISE: rd_mux = DATA_W'(rise_q);
      SEL_FALL: rd_mux = DATA_W'(fall_q);
      SEL_STAT: rd_mux = DATA_W'(status_i);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end

  // R2
  rise_wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_RISE_EN) |=> (rise_en_o == $past(wdata[NSRC-1:0])));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_o));
endmodule

// File: rtl/eisu_status.sv
module eisu_status #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] status_o,
  output logic            irq_o
);
  logic [NSRC-1:0] status_q;

  function automatic logic [NSRC-1:0] next_status(input logic [NSRC-1:0] cur,
                                                  input logic [NSRC-1:0] set,
                                                  input logic [NSRC-1:0] clr);
    return (cur | set) & ~clr;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_q <= next_status(status_q, set_i, clr_i);
      irq_o    <= |status_q;
    end
  end

  assign status_o = status_q;

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|status_q)));
  // R8
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_i)) == '0));
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_i)) == '0));
  // R3
  set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import eisu_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [NSRC-1:0] rise_en_w, fall_en_w, clr_mask_w, set_w, status_w;

  eisu_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr_i), .rd_en(bus_rd_i), .addr(bus_addr_i), .wdata(bus_wdata_i),
    .status_i(status_w),
    .rise_en_o(rise_en_w), .fall_en_o(fall_en_w), .clr_mask_o(clr_mask_w),
    .rdata_o(bus_rdata_o)
  );

  eisu_edge_det #(.NSRC(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .rise_en_i(rise_en_w), .fall_en_i(fall_en_w), .set_o(set_w)
  );

  eisu_status #(.NSRC(NSRC)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(clr_mask_w),
    .status_o(status_w), .irq_o(irq_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_o && bus_rdata_o == '0));
endmodule

// File: tb/test_edge_irq_unit.sv
module test_edge_irq_unit;
  import eisu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  edge_irq_unit i_edge_irq_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read value once the registered data is out
  always @(posedge clk) begin
    if (rd) begin
      @(negedge clk);
      if (sb_q.size() == 0) check("R11 scoreboard empty", 16'h1, 16'h0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rdata, e.exp);
      end
    end
  end

  task automatic bus_write(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); rd = 1'b1; addr = a;
    sb_q.push_back('{exp, tag});
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic drive_evt(input logic [15:0] v);
    @(negedge clk); evt = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check("watchdog", 16'h1, 16'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {15'b0, irq}, 16'h0);
    check("R1 rdata", rdata, 16'h0);
    bus_read(ADDR_RISE_EN, 16'h0, "R1 rise reg");
    bus_read(ADDR_FALL_EN, 16'h0, "R1 fall reg");
    bus_read(ADDR_STS_CLR, 16'h0, "R1 status");

    // R2 enables read back
    bus_write(ADDR_RISE_EN, 16'h1801);
    bus_write(ADDR_FALL_EN, 16'h0002);
    bus_read(ADDR_RISE_EN, 16'h1801, "R2 rise readback");
    bus_read(ADDR_FALL_EN, 16'h0002, "R2 fall readback");

    // R3 conversion-done rising; R10 irq one clock later
    drive_evt(16'h0800);
    @(negedge clk);
    check("R10 irq not yet", {15'b0, irq}, 16'h0);
    @(negedge clk);
    check("R10 irq high", {15'b0, irq}, 16'h1);
    bus_read(ADDR_STS_CLR, 16'h0800, "R3 rise sets bit11");

    // R5/R6 falling with no fall enable; bit stays
    drive_evt(16'h0000);
    bus_read(ADDR_STS_CLR, 16'h0800, "R6 sticky, R5 disabled fall");

    // R5 rise on line 1 not enabled, then R4 fall enabled
    drive_evt(16'h0002);
    bus_read(ADDR_STS_CLR, 16'h0800, "R5 rise disabled line1");
    drive_evt(16'h0000);
    bus_read(ADDR_STS_CLR, 16'h0802, "R4 fall sets bit1");

    // R3 panel contact
    drive_evt(16'h1000);
    bus_read(ADDR_STS_CLR, 16'h1802, "R3 rise sets bit12");

    // R7 partial clear
    bus_write(ADDR_STS_CLR, 16'h0800);
    bus_write(ADDR_STS_CLR, 16'h0000);
    bus_read(ADDR_STS_CLR, 16'h1002, "R7 partial clear");
    check("R10 irq stays", {15'b0, irq}, 16'h1);

    // R8 held clear blocks capture
    bus_write(ADDR_STS_CLR, 16'h1000);
    drive_evt(16'h0000);
    drive_evt(16'h1000);
    bus_read(ADDR_STS_CLR, 16'h0002, "R8 held clear drops edge");
    bus_write(ADDR_STS_CLR, 16'h0000);
    drive_evt(16'h0000);
    drive_evt(16'h1000);
    bus_read(ADDR_STS_CLR, 16'h1002, "R8 capture resumes");

    // R9 clear all; R10 irq drops one clock later
    bus_write(ADDR_STS_CLR, 16'hFFFF);
    check("R10 irq still high on clear clock", {15'b0, irq}, 16'h1);
    @(negedge clk);
    check("R10 irq low after clear", {15'b0, irq}, 16'h0);
    bus_write(ADDR_STS_CLR, 16'h0000);
    bus_read(ADDR_STS_CLR, 16'h0000, "R9 clear all");

    // R5 falling capture off
    bus_write(ADDR_FALL_EN, 16'h0000);
    bus_read(ADDR_FALL_EN, 16'h0000, "R2 fall zero readback");
    drive_evt(16'h1002);
    drive_evt(16'h0000);
    bus_read(ADDR_STS_CLR, 16'h0000, "R5 fall capture off");

    // R11 unmapped read and write
    bus_write(7'h10, 16'hFFFF);
    bus_read(7'h10, 16'h0000, "R11 unmapped read");
    bus_read(ADDR_RISE_EN, 16'h1801, "R11 unmapped write no effect");

    // R3 simultaneous rises
    drive_evt(16'hFFFF);
    bus_read(ADDR_STS_CLR, 16'h1801, "R3 simultaneous rises");
    @(negedge clk);
    check("R10 irq multi", {15'b0, irq}, 16'h1);

    repeat (3) @(negedge clk);
    check("R11 scoreboard drained", 16'(sb_q.size()), 16'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule